// File: doc/BRIEF.md
# CAN Transmit Buffer Status Controller

This block keeps the occupancy state of three transmit message buffers in a CAN controller and produces the transmit-empty interrupt request. Software loads a message into a buffer, then clears that buffer's empty flag to mark it as scheduled for transmission. The protocol engine later reports either a successful transmission or a completed abort for that buffer. Either report sets the flag again, and the buffer is then free for the next message.

The CPU side is a small register bus with read and write strobes and two registers. The status register holds the empty flags, and the enable register holds one interrupt enable per buffer. The scheduler reads the inverted flags as a pending mask. The message-storage logic receives one access-block line per buffer, and this line is high while the buffer is scheduled. An initialization-mode handshake forces the enable register to its reset value while both handshake lines are high. The enable register accepts writes only when both lines are low.

Top module: `can_txbuf_status`

## Requirements
- R1: A synchronous active-high reset sets all three empty flags to 1, clears the enable register to 0 and drives `irq` low.
- R2: A bus write with `bus_addr`=0 (status register) clears empty flag i on the next clock edge when `bus_wdata[i]` is 1. A data bit of 0 leaves that flag unchanged. Only writes can make a flag fall.
- R3: A one-cycle pulse on `tx_done[i]` sets empty flag i on the next clock edge.
- R4: A one-cycle pulse on `abort_done[i]` sets empty flag i on the next clock edge.
- R5: When a hardware set (R3/R4) and a CPU clear hit the same flag in the same cycle, the flag ends up set.
- R6: `pending_mask[i]` and `access_block[i]` are both the inverse of empty flag i, with no extra delay.
- R7: A bus write with `bus_addr`=1 (enable register) loads `bus_wdata[2:0]` into the three enables when `init_req`=0 and `init_ack`=0. Data bits 7:3 are discarded.
- R8: While `init_req`=1 and `init_ack`=1, the enable register is held at 0, and writes to it have no effect.
- R9: While exactly one of `init_req` and `init_ack` is 1, writes to the enable register are ignored and its value is retained.
- R10: `irq` is the OR over the buffers of (empty flag AND enable), registered with one clock cycle of latency.
- R11: While `bus_rd`=1, `bus_rdata` returns the flags (`bus_addr`=0) or the enables (`bus_addr`=1) in bits 2:0, with bits 7:3 reading 0. While `bus_rd`=0, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Register select: 0 status, 1 enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| init_req | input | 1 | Initialization-mode request |
| init_ack | input | 1 | Initialization-mode acknowledge |
| tx_done | input | 3 | Per-buffer transmit-success pulse |
| abort_done | input | 3 | Per-buffer abort-completed pulse |
| empty_flags | output | 3 | Per-buffer empty flags |
| pending_mask | output | 3 | Buffers scheduled for transmission |
| access_block | output | 3 | Per-buffer storage access lock |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
The corner case that is hardest to reach from the ports is the collision, where software's clear and the engine's set land on the same flag in the same cycle. The stimulus reaches it with vectors that raise the write strobe and a completion pulse together. The other hard case is the partial handshake, where exactly one of the initialization lines is high. The directed tests hold one line high at a time, then both, and check that the enable register keeps its value, is forced to zero, and then becomes writable again.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

    localparam int NUM_BUF = 3;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 1'b0,
        REG_IRQEN  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_req_t;

    typedef enum logic [1:0] {
        INIT_OFF    = 2'd0,
        INIT_ACTIVE = 2'd1,
        INIT_SWITCH = 2'd2
    } init_state_e;

    function automatic init_state_e decode_init(input logic req, input logic ack);
        if (req && ack)        return INIT_ACTIVE;
        else if (!req && !ack) return INIT_OFF;
        else                   return INIT_SWITCH;
    endfunction

endpackage

// File: rtl/txbuf_flag_cell.sv
module txbuf_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic empty_q
);
    always_ff @(posedge clk) begin
        if (rst)          empty_q <= 1'b1;
        else if (set_req) empty_q <= 1'b1;
        else if (clr_req) empty_q <= 1'b0;
    end
endmodule

// File: rtl/txbuf_irqen_reg.sv
module txbuf_irqen_reg
    import txbuf_pkg::*;
#(
    parameter int NBUF = NUM_BUF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            init_req,
    input  logic            init_ack,
    input  logic            wr_stb,
    input  logic [NBUF-1:0] wr_data,
    output logic [NBUF-1:0] en_q
);
    init_state_e mode;
    assign mode = decode_init(init_req, init_ack);

    always_ff @(posedge clk) begin
        if (rst || mode == INIT_ACTIVE) begin
            en_q <= '0;
        end else if (wr_stb && mode == INIT_OFF) begin
            en_q <= wr_data;
        end
    end
endmodule

// File: rtl/txbuf_irq_gen.sv
module txbuf_irq_gen #(
    parameter int NBUF = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NBUF-1:0] flags,
    input  logic [NBUF-1:0] enables,
    output logic            irq_q
);
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(flags & enables);
    end
endmodule

// File: rtl/can_txbuf_status.sv
module can_txbuf_status
    import txbuf_pkg::*;
#(
    parameter int NBUF = NUM_BUF,
    parameter int DW   = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic            bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            init_req,
    input  logic            init_ack,
    input  logic [NBUF-1:0] tx_done,
    input  logic [NBUF-1:0] abort_done,
    output logic [NBUF-1:0] empty_flags,
    output logic [NBUF-1:0] pending_mask,
    output logic [NBUF-1:0] access_block,
    output logic            irq
);
    localparam int PAD_W = DW - NBUF;

    bus_req_t        req;
    logic [NBUF-1:0] flag_q;
    logic [NBUF-1:0] irqen_q;
    logic [NBUF-1:0] hw_set;
    logic [NBUF-1:0] sw_clr;

    assign req.wr  = bus_wr;
    assign req.rd  = bus_rd;
    assign req.sel = reg_sel_e'(bus_addr);

    assign hw_set = tx_done | abort_done;
    assign sw_clr = (req.wr && req.sel == REG_STATUS) ? bus_wdata[NBUF-1:0] : '0;

    for (genvar b = 0; b < NBUF; b++) begin : g_flag
        txbuf_flag_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .set_req (hw_set[b]),
            .clr_req (sw_clr[b]),
            .empty_q (flag_q[b])
        );
    end

    txbuf_irqen_reg #(.NBUF(NBUF)) u_irqen (
        .clk      (clk),
        .rst      (rst),
        .init_req (init_req),
        .init_ack (init_ack),
        .wr_stb   (req.wr && req.sel == REG_IRQEN),
        .wr_data  (bus_wdata[NBUF-1:0]),
        .en_q     (irqen_q)
    );

    txbuf_irq_gen #(.NBUF(NBUF)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .flags   (flag_q),
        .enables (irqen_q),
        .irq_q   (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (req.rd) begin
            case (req.sel)
                REG_STATUS: bus_rdata = {{PAD_W{1'b0}}, flag_q};
                REG_IRQEN:  bus_rdata = {{PAD_W{1'b0}}, irqen_q};
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign empty_flags  = flag_q;
    assign pending_mask = ~flag_q;
    assign access_block = ~flag_q;
endmodule

// File: rtl/txbuf_status_chk.sv
module txbuf_status_chk #(
    parameter int NBUF = 3,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_wr,
    input logic            bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic            init_req,
    input logic            init_ack,
    input logic [NBUF-1:0] tx_done,
    input logic [NBUF-1:0] abort_done,
    input logic [NBUF-1:0] empty_flags,
    input logic [NBUF-1:0] en_q,
    input logic            irq
);
    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            // R1
            reset_state_chk: assert (empty_flags == '1 && en_q == '0 && !irq)
                else $error("reset state wrong");
        end
    end

    // R2
    clear_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr && |(bus_wdata[NBUF-1:0] & ~(tx_done | abort_done)))
        |=> ((empty_flags & $past(bus_wdata[NBUF-1:0] & ~(tx_done | abort_done))) == '0));

    // R2
    fall_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        |(~empty_flags & $past(empty_flags)) |-> $past(bus_wr && !bus_addr));

    // R3 R4 R5
    hw_set_chk: assert property (@(posedge clk) disable iff (rst)
        |(tx_done | abort_done)
        |=> ((empty_flags & $past(tx_done | abort_done)) == $past(tx_done | abort_done)));

    // R8
    init_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (init_req && init_ack) |=> (en_q == '0));

    // R9
    partial_init_chk: assert property (@(posedge clk) disable iff (rst)
        (init_req != init_ack) |=> $stable(en_q));

    // R10
    irq_latency_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|(empty_flags & en_q))));
endmodule

bind can_txbuf_status txbuf_status_chk #(.NBUF(NBUF), .DW(DW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .init_req    (init_req),
    .init_ack    (init_ack),
    .tx_done     (tx_done),
    .abort_done  (abort_done),
    .empty_flags (empty_flags),
    .en_q        (irqen_q),
    .irq         (irq)
);

// File: tb/can_txbuf_status_tb.sv
module can_txbuf_status_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr, bus_rd, bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       init_req, init_ack;
    logic [2:0] tx_done, abort_done;
    logic [2:0] empty_flags, pending_mask, access_block;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    can_txbuf_status dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .init_req(init_req),
        .init_ack(init_ack), .tx_done(tx_done), .abort_done(abort_done),
        .empty_flags(empty_flags), .pending_mask(pending_mask),
        .access_block(access_block), .irq(irq)
    );

    // Layout: wr[21] addr[20] wdata[19:12] tx[11:9] abort[8:6] exp_flags[5:3] exp_en[2:0]
    localparam logic [21:0] VEC [12] = '{
        {1'b1, 1'b1, 8'h07, 3'b000, 3'b000, 3'b111, 3'b111}, // R7 enable all
        {1'b1, 1'b0, 8'h01, 3'b000, 3'b000, 3'b110, 3'b111}, // R2 clear buf0
        {1'b1, 1'b0, 8'h06, 3'b000, 3'b000, 3'b000, 3'b111}, // R2 clear buf1,2
        {1'b1, 1'b0, 8'h00, 3'b000, 3'b000, 3'b000, 3'b111}, // R2 zeros no effect
        {1'b0, 1'b0, 8'h00, 3'b001, 3'b000, 3'b001, 3'b111}, // R3 sent buf0
        {1'b0, 1'b0, 8'h00, 3'b000, 3'b010, 3'b011, 3'b111}, // R4 abort buf1
        {1'b1, 1'b0, 8'h04, 3'b100, 3'b000, 3'b111, 3'b111}, // R5 sent vs clear
        {1'b1, 1'b0, 8'h03, 3'b000, 3'b000, 3'b100, 3'b111}, // R2
        {1'b1, 1'b1, 8'hF8, 3'b000, 3'b000, 3'b100, 3'b000}, // R7 upper bits dropped
        {1'b1, 1'b0, 8'h04, 3'b000, 3'b100, 3'b100, 3'b000}, // R5 abort vs clear
        {1'b1, 1'b0, 8'h04, 3'b000, 3'b000, 3'b000, 3'b000}, // R2
        {1'b0, 1'b0, 8'h00, 3'b111, 3'b000, 3'b111, 3'b000}  // R3 all sent
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        tx_done = 0; abort_done = 0;
    endtask

    task automatic read_reg(input logic a, output logic [7:0] d);
        bus_rd = 1; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_rd = 0; bus_addr = 0;
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        idle();
    endtask

    initial begin
        #150000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        idle();
        init_req = 0; init_ack = 0; rst = 1;
        repeat (3) tick();
        rst = 0;

        // R1 reset state
        chk("R1 flags", {5'b0, empty_flags}, 8'h07);
        read_reg(1'b1, rd);
        chk("R1 enables", rd, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        // R11 idle read data
        chk("R11 rdata idle", bus_rdata, 8'h00);

        for (int i = 0; i < 12; i++) begin
            bus_wr     = VEC[i][21];
            bus_addr   = VEC[i][20];
            bus_wdata  = VEC[i][19:12];
            tx_done    = VEC[i][11:9];
            abort_done = VEC[i][8:6];
            tick();
            idle();
            chk($sformatf("R2-group vec%0d flags", i), {5'b0, empty_flags}, {5'b0, VEC[i][5:3]});
            chk($sformatf("R6 vec%0d pending", i), {5'b0, pending_mask}, {5'b0, ~VEC[i][5:3]});
            chk($sformatf("R6 vec%0d block", i), {5'b0, access_block}, {5'b0, ~VEC[i][5:3]});
            read_reg(1'b0, rd);
            chk($sformatf("R11 vec%0d status read", i), rd, {5'b0, VEC[i][5:3]});
            read_reg(1'b1, rd);
            chk($sformatf("R7 vec%0d enable read", i), rd, {5'b0, VEC[i][2:0]});
        end

        // R10 latency: flags 111, enables 000
        chk("R10 irq off", {7'b0, irq}, 8'h00);
        wr_reg(1'b1, 8'h01);
        chk("R10 irq not yet", {7'b0, irq}, 8'h00);
        tick();
        chk("R10 irq raised", {7'b0, irq}, 8'h01);
        wr_reg(1'b0, 8'h01);
        chk("R10 irq still high", {7'b0, irq}, 8'h01);
        tick();
        chk("R10 irq dropped", {7'b0, irq}, 8'h00);

        // R11 unimplemented bits
        wr_reg(1'b1, 8'hFF);
        read_reg(1'b1, rd);
        chk("R11 upper bits zero", rd, 8'h07);

        // R9 partial handshake
        wr_reg(1'b1, 8'h05);
        init_req = 1;
        wr_reg(1'b1, 8'h02);
        read_reg(1'b1, rd);
        chk("R9 req only holds", rd, 8'h05);
        init_req = 0; init_ack = 1;
        wr_reg(1'b1, 8'h02);
        read_reg(1'b1, rd);
        chk("R9 ack only holds", rd, 8'h05);

        // R8 init active
        init_req = 1;
        tick();
        read_reg(1'b1, rd);
        chk("R8 forced zero", rd, 8'h00);
        wr_reg(1'b1, 8'h07);
        read_reg(1'b1, rd);
        chk("R8 write ignored", rd, 8'h00);

        init_req = 0; init_ack = 0;
        wr_reg(1'b1, 8'h03);
        read_reg(1'b1, rd);
        chk("R7 writable after init", rd, 8'h03);

        // R1 reset mid-run
        wr_reg(1'b0, 8'h07);
        rst = 1; tick(); rst = 0;
        chk("R1 flags after rst", {5'b0, empty_flags}, 8'h07);
        read_reg(1'b1, rd);
        chk("R1 enables after rst", rd, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule